// File: doc/BRIEF.md
# Multiplexed Video DRAM Access Sequencer

This block sits between a video processor's access arbiter and a bank of 8-bit DRAM. The DRAM holds 128 kB, reached through an 8-bit multiplexed address bus. One request comes in at a time: a single read, a single write, a same-row burst read, a two-bank interleaved burst read or a refresh. The block turns it into a cycle-exact sequence of row and column address phases. It drives an active-low row strobe, two active-low column strobes (one for each 64 kB bank) and a read/write line. Read bytes come back on a strobed port, each tagged with its position inside the burst.

A mode input chooses between linear and interleaved addressing. In interleaved mode the logical address is rotated right by one bit before use. Even logical bytes then sit in bank 0 and odd ones in bank 1, at the same row and column. This lets an eight-byte two-bank burst alternate the two column strobes under a single row strobe. Refresh is an ordinary six-cycle read. Its logical address is produced by an internal counter, so every row is visited in turn.

The caller presents a request when `busy_o` is low. The request is taken on that clock edge. `busy_o` drops in the last cycle of the access, so the next request can follow with no idle cycle.

Top module: `dram_access_seq`

## Requirements
- R1: After reset the block is idle: `busy_o` low, row strobe high, both column strobes high (inactive), read/write high (read), data drive enable low, no read strobe.
- R2: Kind code 0 (single read) lasts 6 cycles. The row phase carries physical address bits 15..8, the column phase carries bits 7..0, and only the column strobe of bank bit 16 goes low, for 2 cycles. The row strobe is low for 4 cycles, and exactly one byte is returned with index 0.
- R3: Kind code 1 (single write) lasts 6 cycles. The read/write line is low, and the write byte is driven with its enable high, for exactly 3 cycles in the column phase. The selected bank's column strobe falls while the byte is driven, and no read byte is returned.
- R4: Kind code 2 (same-row burst read) with length field N-1 (N of 1 to 3) lasts 2+4N cycles. It returns N bytes from consecutive columns of one row, with indices 0 to N-1.
- R5: A same-row burst of the maximum length (4 bytes, length field 3) is padded so that it lasts 20 cycles, holding the row strobe low for 18 of them.
- R6: When the interleave input is high at acceptance, the physical address is the 17-bit logical address rotated right by one bit. Even logical addresses therefore use bank 0 and odd ones bank 1. When the input is low, physical equals logical.
- R7: Kind code 3 (two-bank burst read) ignores logical address bit 0 and lasts 20 cycles. Each column strobe goes low 4 times, and 8 bytes are returned: byte i is logical start+i, with index i.
- R8: Kind code 4 (refresh) is a 6-cycle read that returns no byte. Its logical address is N*0x10101 with the low six bits forced to one, where N counts refreshes from 0 after reset.
- R9: `busy_o` is high from the cycle after acceptance up to the second-to-last cycle of the access and low in the last cycle. A request presented while `busy_o` is high is ignored, and one presented in the last cycle starts the next access at once.
- R10: Kind codes 5, 6 and 7 are ignored: `busy_o` stays low and the DRAM bus stays idle.
- R11: Column addresses inside a burst wrap within the row (column 0xFF is followed by 0x00 of the same row).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_kind_i | input | 3 | Access kind code |
| req_addr_i | input | 17 | Logical byte address |
| req_len_i | input | 2 | Same-row burst length minus one |
| req_wdata_i | input | 8 | Byte to write |
| il_mode_i | input | 1 | Interleaved addressing mode |
| busy_o | output | 1 | Access in progress, new requests not taken |
| rd_valid_o | output | 1 | Read byte strobe |
| rd_data_o | output | 8 | Read byte |
| rd_index_o | output | 3 | Byte position inside the burst |
| dram_addr_o | output | 8 | Multiplexed row/column address |
| dram_ras_n_o | output | 1 | Row strobe, active low |
| dram_cas_n_o | output | 2 | Column strobes of bank 0 and bank 1, active low |
| dram_we_n_o | output | 1 | Read/write line, low for write |
| dram_dq_o | output | 8 | Write data |
| dram_dq_oe_o | output | 1 | Write data drive enable |
| dram_dq_i | input | 8 | Read data from DRAM |

## Verification
The bench uses a DRAM model whose byte depends on bank, row and column, so a wrong bank, row or column gives a wrong byte. Single accesses are tried at even and odd addresses, in both addressing modes and in both halves of the space. This separates the rotation from a plain bank-bit decode. Bursts of every length tell apart the cycle count of each length, the padding of the longest one and the column wrap at a row end. An odd start address shows that the two-bank burst drops bit 0. Refreshes in both modes check the counter sequence and that interleaved refresh always lands in bank 1. Requests sent during an access, on its last cycle and with unused kind codes check the handshake.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

   typedef enum logic [2:0] {
      K_RD      = 3'd0,
      K_WR      = 3'd1,
      K_BURST   = 3'd2,
      K_DUAL    = 3'd3,
      K_REFRESH = 3'd4
   } acc_kind_e;

   // Codes above the last defined kind are not accepted.
   function automatic logic kind_ok(input logic [2:0] k);
      return k <= 3'(K_REFRESH);
   endfunction

endpackage

// File: rtl/dseq_addr_map.sv
// Logical-to-physical address mapping; rotation variant chosen by parameter.
module dseq_addr_map #(
   parameter int unsigned AW     = 17,
   parameter bit          ROT_EN = 1'b1
) (
   input  logic [AW-1:0] log_i,
   input  logic          il_i,
   output logic [AW-1:0] phys_o
);

   generate
      if (ROT_EN) begin : g_rot
         // Rotate right by one: bit 0 becomes the bank bit.
         assign phys_o = il_i ? {log_i[0], log_i[AW-1:1]} : log_i;
      end else begin : g_pass
         logic unused_il;
         assign unused_il = il_i;
         assign phys_o    = log_i;
      end
   endgenerate

endmodule

// File: rtl/dseq_refresh_ctr.sv
// Refresh address source: N repeated in every byte lane, low bits forced high.
module dseq_refresh_ctr #(
   parameter int unsigned RW       = 8,
   parameter int unsigned LOW_ONES = 6
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          step_i,
   output logic [2*RW:0] log_addr_o
);

   localparam logic [RW-1:0] ONES = RW'((1 << LOW_ONES) - 1);

   logic [RW-1:0] n_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     n_q <= '0;
      else if (step_i) n_q <= n_q + RW'(1);
   end

   // N * 0x10101 truncated to 2*RW+1 bits: no lane carries into another.
   assign log_addr_o = {n_q[0], n_q, n_q | ONES};

endmodule

// File: rtl/dseq_phase_gen.sv
// Cycle counter and phase decode shared by all access kinds.
module dseq_phase_gen
   import dseq_pkg::*;
#(
   parameter int unsigned MAX_BURST = 4,
   parameter bit          PAD_FULL  = 1'b1,
   localparam int unsigned LEN_W    = $clog2(MAX_BURST),
   localparam int unsigned NS_W     = $clog2(MAX_BURST + 1),
   localparam int unsigned T_W      = $clog2(4 * MAX_BURST + 5)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic [2:0]       kind_i,
   input  logic [LEN_W-1:0] len_i,
   output logic             active_o,
   output logic             final_o,
   output logic             row_phase_o,
   output logic             ras_on_o,
   output logic             in_slot_o,
   output logic [1:0]       ph_o,
   output logic [LEN_W-1:0] slot_o,
   output logic [2:0]       kind_o
);

   logic             active_q;
   logic [T_W-1:0]   t_q, last_q, last_d;
   logic [NS_W-1:0]  ns_q, ns_d;
   logic [2:0]       kind_q;
   logic             pad_d;

   // Slot count and access length: 2 + 4 per slot, +2 for padded bursts.
   always_comb begin
      case (kind_i)
         K_BURST: ns_d = NS_W'(len_i) + NS_W'(1);
         K_DUAL:  ns_d = NS_W'(MAX_BURST);
         default: ns_d = NS_W'(1);
      endcase
      pad_d  = (kind_i == K_DUAL) ||
               (PAD_FULL && (kind_i == K_BURST) && (ns_d == NS_W'(MAX_BURST)));
      last_d = T_W'(4 * int'(ns_d) + (pad_d ? 3 : 1));
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         active_q <= 1'b0;
         t_q      <= '0;
         last_q   <= '0;
         ns_q     <= '0;
         kind_q   <= '0;
      end else if (start_i) begin
         active_q <= 1'b1;
         t_q      <= '0;
         last_q   <= last_d;
         ns_q     <= ns_d;
         kind_q   <= kind_i;
      end else if (active_q) begin
         if (t_q == last_q) active_q <= 1'b0;
         else               t_q      <= t_q + T_W'(1);
      end
   end

   // Each slot is four cycles: column setup, strobe A, strobe B, gap.
   logic [T_W-1:0] u, k_full;
   logic           past_row;

   assign u        = t_q - T_W'(2);
   assign k_full   = u >> 2;
   assign past_row = (t_q >= T_W'(2));

   assign ph_o        = u[1:0];
   assign in_slot_o   = active_q && past_row && (k_full < T_W'(ns_q));
   assign slot_o      = (k_full >= T_W'(ns_q)) ? LEN_W'(ns_q - NS_W'(1)) : LEN_W'(k_full);
   assign active_o    = active_q;
   assign final_o     = active_q && (t_q == last_q);
   assign row_phase_o = active_q && !past_row;
   assign ras_on_o    = active_q && (t_q != '0) && (t_q != last_q);
   assign kind_o      = kind_q;

endmodule

// File: rtl/dram_access_seq.sv
module dram_access_seq
   import dseq_pkg::*;
#(
   parameter int unsigned MUX_W     = 8,
   parameter int unsigned MAX_BURST = 4,
   parameter bit          PAD_FULL  = 1'b1,
   parameter bit          ROT_EN    = 1'b1
) (
   input  logic                         clk_i,
   input  logic                         rst_ni,
   input  logic                         req_valid_i,
   input  logic [2:0]                   req_kind_i,
   input  logic [2*MUX_W:0]             req_addr_i,
   input  logic [$clog2(MAX_BURST)-1:0] req_len_i,
   input  logic [MUX_W-1:0]             req_wdata_i,
   input  logic                         il_mode_i,
   output logic                         busy_o,
   output logic                         rd_valid_o,
   output logic [MUX_W-1:0]             rd_data_o,
   output logic [$clog2(MAX_BURST):0]   rd_index_o,
   output logic [MUX_W-1:0]             dram_addr_o,
   output logic                         dram_ras_n_o,
   output logic [1:0]                   dram_cas_n_o,
   output logic                         dram_we_n_o,
   output logic [MUX_W-1:0]             dram_dq_o,
   output logic                         dram_dq_oe_o,
   input  logic [MUX_W-1:0]             dram_dq_i
);

   localparam int unsigned AW    = 2 * MUX_W + 1;
   localparam int unsigned LEN_W = $clog2(MAX_BURST);
   localparam int unsigned IDX_W = LEN_W + 1;

   generate
      if (MUX_W < 2) begin : g_bad_mux
         $error("MUX_W must be at least 2");
      end
      if (MAX_BURST < 2 || (MAX_BURST & (MAX_BURST - 1)) != 0) begin : g_bad_burst
         $error("MAX_BURST must be a power of two, at least 2");
      end
   endgenerate

   // Acceptance and address selection
   logic          accept;
   logic [AW-1:0] ref_log, log_sel, phys;

   assign accept = req_valid_i && !busy_o && kind_ok(req_kind_i);

   always_comb begin
      if (req_kind_i == K_REFRESH)   log_sel = ref_log;
      else if (req_kind_i == K_DUAL) log_sel = {req_addr_i[AW-1:1], 1'b0};
      else                           log_sel = req_addr_i;
   end

   dseq_refresh_ctr #(.RW(MUX_W), .LOW_ONES(6)) u_ref (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .step_i    (accept && (req_kind_i == K_REFRESH)),
      .log_addr_o(ref_log)
   );

   dseq_addr_map #(.AW(AW), .ROT_EN(ROT_EN)) u_map (
      .log_i (log_sel),
      .il_i  (il_mode_i),
      .phys_o(phys)
   );

   // Phase generator
   logic             active, final_w, row_phase, ras_on, in_slot;
   logic [1:0]       ph;
   logic [LEN_W-1:0] slot;
   logic [2:0]       kind_w;

   dseq_phase_gen #(.MAX_BURST(MAX_BURST), .PAD_FULL(PAD_FULL)) u_phase (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .start_i    (accept),
      .kind_i     (req_kind_i),
      .len_i      (req_len_i),
      .active_o   (active),
      .final_o    (final_w),
      .row_phase_o(row_phase),
      .ras_on_o   (ras_on),
      .in_slot_o  (in_slot),
      .ph_o       (ph),
      .slot_o     (slot),
      .kind_o     (kind_w)
   );

   // Latched physical address and write byte
   logic [MUX_W-1:0] row_q, col_q, wdata_q;
   logic             bank_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         row_q   <= '0;
         col_q   <= '0;
         bank_q  <= 1'b0;
         wdata_q <= '0;
      end else if (accept) begin
         row_q   <= phys[2*MUX_W-1:MUX_W];
         col_q   <= phys[MUX_W-1:0];
         bank_q  <= phys[AW-1];
         wdata_q <= req_wdata_i;
      end
   end

   // Bus decode
   logic is_dual, is_wr, is_ref, col_phase, sample;
   logic [1:0] cas_n;

   assign is_dual = (kind_w == K_DUAL);
   assign is_wr   = (kind_w == K_WR);
   assign is_ref  = (kind_w == K_REFRESH);

   always_comb begin
      cas_n = 2'b11;
      if (in_slot) begin
         if (is_dual) begin
            if (ph == 2'd1) cas_n[0] = 1'b0;
            if (ph == 2'd2) cas_n[1] = 1'b0;
         end else if (ph == 2'd1 || ph == 2'd2) begin
            cas_n[bank_q] = 1'b0;
         end
      end
   end

   assign col_phase = in_slot && (ph != 2'd3);
   assign sample    = in_slot && !is_wr && !is_ref &&
                      (is_dual ? (ph == 2'd1 || ph == 2'd2) : (ph == 2'd2));

   assign busy_o       = active && !final_w;
   assign dram_ras_n_o = !ras_on;
   assign dram_cas_n_o = cas_n;
   assign dram_we_n_o  = !(is_wr && col_phase);
   assign dram_dq_oe_o = is_wr && col_phase;
   assign dram_dq_o    = dram_dq_oe_o ? wdata_q : '0;
   assign dram_addr_o  = !active ? '0 : (row_phase ? row_q : col_q + MUX_W'(slot));

   // Read return, one cycle after the sampling strobe
   logic             rd_valid_q;
   logic [MUX_W-1:0] rd_data_q;
   logic [IDX_W-1:0] rd_index_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rd_valid_q <= 1'b0;
         rd_data_q  <= '0;
         rd_index_q <= '0;
      end else begin
         rd_valid_q <= sample;
         if (sample) begin
            rd_data_q  <= dram_dq_i;
            rd_index_q <= is_dual ? {slot, ph == 2'd2} : {1'b0, slot};
         end
      end
   end

   assign rd_valid_o = rd_valid_q;
   assign rd_data_o  = rd_data_q;
   assign rd_index_o = rd_index_q;

endmodule

// File: rtl/dram_access_seq_chk.sv
module dram_access_seq_chk (
   input logic       clk_i,
   input logic       rst_ni,
   input logic       req_valid_i,
   input logic [2:0] req_kind_i,
   input logic       busy_o,
   input logic       rd_valid_o,
   input logic       dram_ras_n_o,
   input logic [1:0] dram_cas_n_o,
   input logic       dram_we_n_o,
   input logic       dram_dq_oe_o
);

   assert_cas_under_ras_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dram_cas_n_o != 2'b11) |-> !dram_ras_n_o);

   assert_ras_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(dram_ras_n_o) |=> !dram_ras_n_o);

   assert_read_after_cas_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_valid_o |-> ($past(dram_cas_n_o) != 2'b11));

   assert_drive_on_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dram_dq_oe_o |-> (!dram_we_n_o && !dram_ras_n_o));

   assert_one_cas_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(~dram_cas_n_o));

   assert_accept_starts_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && !busy_o && req_kind_i <= 3'd4) |=> (busy_o && dram_ras_n_o));

   assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o |-> (dram_ras_n_o && dram_cas_n_o == 2'b11 && dram_we_n_o));

   assert_bad_kind_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && !busy_o && req_kind_i > 3'd4) |=> !busy_o);

endmodule

bind dram_access_seq dram_access_seq_chk chk_i (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .req_valid_i (req_valid_i),
   .req_kind_i  (req_kind_i),
   .busy_o      (busy_o),
   .rd_valid_o  (rd_valid_o),
   .dram_ras_n_o(dram_ras_n_o),
   .dram_cas_n_o(dram_cas_n_o),
   .dram_we_n_o (dram_we_n_o),
   .dram_dq_oe_o(dram_dq_oe_o)
);

// File: tb/dram_access_seq_tb_top.sv
`timescale 1ns/1ps
module dram_access_seq_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_kind = '0;
   logic [16:0] req_addr = '0;
   logic [1:0]  req_len = '0;
   logic [7:0]  req_wdata = '0;
   logic        il_mode = 1'b0;
   logic        busy_o, rd_valid_o, dram_ras_n_o, dram_we_n_o, dram_dq_oe_o;
   logic [7:0]  rd_data_o, dram_addr_o, dram_dq_o, dram_dq_i;
   logic [2:0]  rd_index_o;
   logic [1:0]  dram_cas_n_o;

   always #2.5 clk = ~clk;

   dram_access_seq dut_i (
      .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_kind_i(req_kind),
      .req_addr_i(req_addr), .req_len_i(req_len), .req_wdata_i(req_wdata),
      .il_mode_i(il_mode), .busy_o(busy_o), .rd_valid_o(rd_valid_o),
      .rd_data_o(rd_data_o), .rd_index_o(rd_index_o), .dram_addr_o(dram_addr_o),
      .dram_ras_n_o(dram_ras_n_o), .dram_cas_n_o(dram_cas_n_o), .dram_we_n_o(dram_we_n_o),
      .dram_dq_o(dram_dq_o), .dram_dq_oe_o(dram_dq_oe_o), .dram_dq_i(dram_dq_i)
   );

   // DRAM model: the byte is a function of bank, row and column.
   function automatic logic [7:0] mdl(input logic b, input logic [7:0] r, input logic [7:0] c);
      return 8'(int'(r) * 7 + int'(c) * 3 + (b ? 85 : 0));
   endfunction

   function automatic logic [16:0] to_phys(input logic [16:0] a, input logic il);
      return il ? {a[0], a[16:1]} : a;
   endfunction

   logic [7:0] row_m = '0;
   always @(negedge clk) if (dram_ras_n_o) row_m = dram_addr_o;

   always_comb begin
      if (!dram_cas_n_o[0])      dram_dq_i = mdl(1'b0, row_m, dram_addr_o);
      else if (!dram_cas_n_o[1]) dram_dq_i = mdl(1'b1, row_m, dram_addr_o);
      else                       dram_dq_i = 8'h00;
   end

   int errors = 0;
   int checks = 0;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Results of the last access
   int         cyc, ras_lo, cas0, cas1, we_lo, oe_cnt, nrd, busy_hi;
   logic [7:0] acc_row, last_col, wr_data, wr_col;
   logic       last_bank, wr_bank;
   logic [7:0] rd_buf [8];

   task automatic run_acc(input logic [2:0] kind, input logic [16:0] addr, input logic [1:0] len,
                          input logic [7:0] wd, input logic il, input int poke);
      @(negedge clk);
      req_valid = 1'b1; req_kind = kind; req_addr = addr;
      req_len = len; req_wdata = wd; il_mode = il;
      @(negedge clk);
      req_valid = 1'b0;
      cyc = 0; ras_lo = 0; cas0 = 0; cas1 = 0; we_lo = 0; oe_cnt = 0; nrd = 0; busy_hi = 0;
      for (int i = 0; i < 8; i++) rd_buf[i] = 8'hxx;
      while (1) begin
         if (cyc == 0) acc_row = dram_addr_o;
         if (!dram_ras_n_o) ras_lo++;
         if (!dram_cas_n_o[0]) begin cas0++; last_bank = 1'b0; last_col = dram_addr_o; end
         if (!dram_cas_n_o[1]) begin cas1++; last_bank = 1'b1; last_col = dram_addr_o; end
         if (!dram_we_n_o) we_lo++;
         if (dram_dq_oe_o) oe_cnt++;
         if (!dram_we_n_o && dram_cas_n_o != 2'b11) begin
            wr_data = dram_dq_o; wr_bank = !dram_cas_n_o[1]; wr_col = dram_addr_o;
         end
         if (rd_valid_o) begin nrd++; rd_buf[rd_index_o] = rd_data_o; end
         if (busy_o) busy_hi++;
         if (cyc == poke) begin req_valid = 1'b1; req_kind = 3'd1; end
         if (cyc == poke + 1) req_valid = 1'b0;
         cyc++;
         if (!busy_o || cyc > 64) break;
         @(negedge clk);
      end
      req_valid = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 busy", busy_o, 0);
      chk("R1 ras", dram_ras_n_o, 1);
      chk("R1 cas", dram_cas_n_o, 3);
      chk("R1 we", dram_we_n_o, 1);
      chk("R1 oe", dram_dq_oe_o, 0);
      chk("R1 rd_valid", rd_valid_o, 0);
   endtask

   task automatic t_single(input logic [16:0] a, input logic il, input string tag);
      logic [16:0] p;
      p = to_phys(a, il);
      run_acc(3'd0, a, 2'd0, 8'h00, il, -10);
      chk({tag, " single cycles"}, cyc, 6);
      chk({tag, " single ras low"}, ras_lo, 4);
      chk({tag, " single row"}, acc_row, p[15:8]);
      chk({tag, " single bank strobes"}, p[16] ? (cas1 == 2 && cas0 == 0) : (cas0 == 2 && cas1 == 0), 1);
      chk({tag, " single byte count"}, nrd, 1);
      chk({tag, " single data"}, rd_buf[0], mdl(p[16], p[15:8], p[7:0]));
      chk("R9 busy length", busy_hi, cyc - 1);
   endtask

   task automatic t_write(input logic [16:0] a, input logic il, input logic [7:0] wd);
      logic [16:0] p;
      p = to_phys(a, il);
      run_acc(3'd1, a, 2'd0, wd, il, -10);
      chk("R3 write cycles", cyc, 6);
      chk("R3 we low", we_lo, 3);
      chk("R3 drive enable", oe_cnt, 3);
      chk("R3 data", wr_data, wd);
      chk("R3 row", acc_row, p[15:8]);
      chk("R3 col", wr_col, p[7:0]);
      chk("R3 bank", wr_bank, p[16]);
      chk("R3 no read", nrd, 0);
   endtask

   task automatic t_burst(input logic [16:0] a, input int n, input string tag);
      int exp_cyc;
      exp_cyc = (n == 4) ? 20 : 2 + 4 * n;
      run_acc(3'd2, a, 2'(n - 1), 8'h00, 1'b0, -10);
      chk({tag, " burst cycles"}, cyc, exp_cyc);
      chk({tag, " burst ras low"}, ras_lo, exp_cyc - 2);
      chk({tag, " burst bytes"}, nrd, n);
      for (int k = 0; k < n; k++)
         chk({tag, " burst data"}, rd_buf[k], mdl(a[16], a[15:8], 8'(a[7:0] + k)));
   endtask

   task automatic t_dual(input logic [16:0] a);
      logic [16:0] p;
      p = to_phys({a[16:1], 1'b0}, 1'b1);
      run_acc(3'd3, a, 2'd0, 8'h00, 1'b1, -10);
      chk("R7 dual cycles", cyc, 20);
      chk("R7 cas0 pulses", cas0, 4);
      chk("R7 cas1 pulses", cas1, 4);
      chk("R7 bytes", nrd, 8);
      for (int i = 0; i < 8; i++)
         chk("R7 dual data", rd_buf[i], mdl(i[0], p[15:8], 8'(p[7:0] + i / 2)));
   endtask

   int ref_n = 0;
   task automatic t_refresh(input logic il);
      logic [7:0]  n;
      logic [16:0] lg, p;
      n  = 8'(ref_n);
      lg = {n[0], n, n | 8'h3F};
      p  = to_phys(lg, il);
      run_acc(3'd4, 17'h0, 2'd0, 8'h00, il, -10);
      ref_n++;
      chk("R8 refresh cycles", cyc, 6);
      chk("R8 refresh no byte", nrd, 0);
      chk("R8 refresh row", acc_row, p[15:8]);
      chk("R8 refresh col", last_col, p[7:0]);
      chk("R8 refresh bank", last_bank, p[16]);
   endtask

   task automatic t_badkind(input logic [2:0] k);
      @(negedge clk);
      req_valid = 1'b1; req_kind = k;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R10 unused kind busy", busy_o, 0);
      chk("R10 unused kind bus", {dram_ras_n_o, dram_cas_n_o}, 3'b111);
   endtask

   task automatic t_poke();
      run_acc(3'd0, 17'h0_2222, 2'd0, 8'h3C, 1'b0, 1);
      chk("R9 request during busy ignored", we_lo, 0);
      chk("R9 access length kept", cyc, 6);
      @(negedge clk);
      chk("R9 idle after", busy_o, 0);
   endtask

   task automatic t_b2b();
      int guard;
      @(negedge clk);
      req_valid = 1'b1; req_kind = 3'd0; req_addr = 17'h0_1111; il_mode = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
      guard = 0;
      while (busy_o && guard < 64) begin @(negedge clk); guard++; end
      req_valid = 1'b1; req_addr = 17'h0_7700;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R9 back-to-back busy", busy_o, 1);
      chk("R9 back-to-back row phase", dram_ras_n_o, 1);
      chk("R9 back-to-back row", dram_addr_o, 8'h77);
      guard = 0;
      while (busy_o && guard < 64) begin @(negedge clk); guard++; end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single(17'h0_1234, 1'b0, "R2");
      t_single(17'h1_ABCD, 1'b0, "R2");
      t_single(17'h0_2468, 1'b1, "R6");
      t_single(17'h1_3579, 1'b1, "R6");
      t_write(17'h1_0F0F, 1'b0, 8'hA5);
      t_write(17'h0_0C41, 1'b1, 8'h5A);
      t_burst(17'h0_4410, 1, "R4");
      t_burst(17'h0_4410, 2, "R4");
      t_burst(17'h1_4410, 3, "R4");
      t_burst(17'h0_6620, 4, "R5");
      t_burst(17'h1_39FE, 4, "R11");
      t_dual(17'h0_5A31);
      t_dual(17'h1_01FE);
      t_refresh(1'b0);
      t_refresh(1'b0);
      t_refresh(1'b0);
      t_refresh(1'b1);
      t_refresh(1'b1);
      t_badkind(3'd5);
      t_badkind(3'd6);
      t_badkind(3'd7);
      t_poke();
      t_b2b();
      repeat (2) @(negedge clk);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule